// File: doc/BRIEF.md
# Receive Character Queue with Trigger and Flow Control

This block sits between a serial receiver and the port a host reads from. Each character the receiver delivers is placed at the tail of a 16-entry first-in first-out store, and the host takes characters from the head one at a time. A two-bit setting picks a fill threshold of 1, 4, 8 or 14 characters. While the fill level is at or above that threshold, the block raises an interrupt request. At the same time it drives an active-low ready-to-send output high, which asks the far end to stop sending.

The block also gates the local transmitter. A transmit request passes through as a start permission only while the active-low clear-to-send input is low. If a character arrives while every entry is occupied and no read takes place in the same cycle, that character is discarded and a sticky overrun flag is raised. The host clears the flag with a single-cycle clear pulse.

Top module: `rx_flow_fifo`

## Requirements
- R1: The store holds up to 16 characters and hands them out in arrival order. `level` gives the number held. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` is 16.
- R2: A read (`rd_en` high while not empty) removes the oldest character, which appears on `rd_data` one clock later and stays there until the next successful read.
- R3: A read while empty leaves `rd_data` and `level` unchanged.
- R4: `trig_sel` encodes the threshold: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. `irq` is high in every cycle in which `level` is at or above the threshold, and low otherwise.
- R5: `rts_n` is high (pause) whenever `level` is at or above the threshold. It is low as soon as `level` is below the threshold, with no hysteresis.
- R6: `tx_go` equals `tx_req` while `cts_n` is low, and is 0 while `cts_n` is high.
- R7: A write (`in_valid`) while full without a read in the same cycle is dropped: `level` stays at 16, the stored characters are unchanged, and `overrun` is 1 from the next clock.
- R8: `overrun` stays set until a cycle with `clr_status` high and no new drop. When a drop and a clear occur in the same cycle, the flag remains set.
- R9: A write and a read in the same cycle while full are both accepted. `level` stays 16 and no overrun is raised.
- R10: After reset, `level` is 0, `empty` is 1, `rd_data` is 0, `overrun` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A received character is offered this cycle |
| in_data | input | 8 | Received character |
| rd_en | input | 1 | Host read request |
| rd_data | output | 8 | Last character read |
| trig_sel | input | 2 | Threshold select (0:1, 1:4, 2:8, 3:14) |
| clr_status | input | 1 | Clears the overrun flag |
| cts_n | input | 1 | Active-low clear-to-send from the far end |
| tx_req | input | 1 | Local transmitter wants to start a character |
| tx_go | output | 1 | Start permission for the local transmitter |
| level | output | 5 | Number of characters held |
| empty | output | 1 | Store holds no character |
| full | output | 1 | Store holds 16 characters |
| irq | output | 1 | Fill level at or above threshold |
| rts_n | output | 1 | Active-low ready-to-send (high asks to pause) |
| overrun | output | 1 | Sticky flag: a character was lost |

## Verification
If the read and write pointers drift apart from the occupancy count, the fault appears on `rd_data` at the first read after the error. That read returns either a stale character or one out of order, and the bench compares every read result against a queue model. A wrong occupancy count moves `level`, `irq` and `rts_n` in the same clock. A missed drop or a missed clear shows on `overrun` one clock after the stimulus. The bench compares every output against the model on every clock, so each of these faults is reported within one cycle of becoming visible.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } trig_sel_e;

  // Threshold in characters for a given select code.
  function automatic int unsigned trig_threshold(input logic [1:0] sel);
    case (sel)
      TRIG_1:  return 32'd1;
      TRIG_4:  return 32'd4;
      TRIG_8:  return 32'd8;
      default: return 32'd14;
    endcase
  endfunction

  // Occupancy after one cycle, given the accepted write and read.
  function automatic int unsigned level_after(input int unsigned cur,
                                              input logic wr, input logic rd);
    case ({wr, rd})
      2'b10:   return cur + 32'd1;
      2'b01:   return cur - 32'd1;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             rd_en,
  input  logic [1:0]       trig_sel,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             drop_evt,
  output logic             at_trig,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  import rxq_pkg::*;

  logic [LVL_W-1:0] level_q;

  assign empty    = (level_q == '0);
  assign full     = (level_q == LVL_W'(DEPTH));
  assign rd_fire  = rd_en && !empty;
  assign wr_fire  = in_valid && (!full || rd_fire);
  assign drop_evt = in_valid && !wr_fire;
  assign at_trig  = (32'(level_q) >= trig_threshold(trig_sel));
  assign level    = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= LVL_W'(level_after(32'(level_q), wr_fire, rd_fire));
  end

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam bit POW2   = ((1 << ADDR_W) == DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr, wptr_nxt, rptr_nxt;

  generate
    if (POW2) begin : g_wrap_nat
      assign wptr_nxt = wptr + 1'b1;
      assign rptr_nxt = rptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_nxt = (wptr == ADDR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nxt = (rptr == ADDR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_fire) wptr <= wptr_nxt;
      if (rd_fire) begin
        rptr    <= rptr_nxt;
        rd_data <= mem[rptr];
      end
    end
  end

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_evt,
  input  logic clr_status,
  input  logic at_trig,
  input  logic cts_n,
  input  logic tx_req,
  output logic irq,
  output logic rts_n,
  output logic tx_go,
  output logic overrun
);

  assign irq   = at_trig;
  assign rts_n = at_trig;
  assign tx_go = tx_req && !cts_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          overrun <= 1'b0;
    else if (drop_evt)   overrun <= 1'b1;
    else if (clr_status) overrun <= 1'b0;
  end

endmodule

// File: rtl/rx_flow_fifo.sv
module rx_flow_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        trig_sel,
  input  logic              clr_status,
  input  logic              cts_n,
  input  logic              tx_req,
  output logic              tx_go,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              irq,
  output logic              rts_n,
  output logic              overrun
);

  logic wr_fire, rd_fire, drop_evt, at_trig;

  rxq_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_en(rd_en),
    .trig_sel(trig_sel), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .drop_evt(drop_evt), .at_trig(at_trig), .level(level),
    .empty(empty), .full(full)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_data(in_data), .rd_data(rd_data)
  );

  rxq_flow u_flow (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt), .clr_status(clr_status),
    .at_trig(at_trig), .cts_n(cts_n), .tx_req(tx_req), .irq(irq),
    .rts_n(rts_n), .tx_go(tx_go), .overrun(overrun)
  );

endmodule

// File: rtl/rx_flow_fifo_chk.sv
module rx_flow_fifo_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic [1:0]        trig_sel,
  input logic              clr_status,
  input logic              cts_n,
  input logic              tx_go,
  input logic [LVL_W-1:0]  level,
  input logic              empty,
  input logic              full,
  input logic              irq,
  input logic              rts_n,
  input logic              overrun,
  input logic              wr_fire,
  input logic              rd_fire,
  input logic              drop_evt
);

  // R1
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  // R1
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire == rd_fire) |=> $stable(level));

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> $stable(rd_data));

  // R4
  trig_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'd0 && !empty) |-> irq);

  // R5
  rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n == irq);

  // R6
  cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cts_n |-> !tx_go);

  // R7
  drop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !rd_en) |=> (full && overrun));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_status) |=> overrun);

  // R9
  full_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && rd_en) |-> (!drop_evt && rd_fire && wr_fire));

endmodule

bind rx_flow_fifo rx_flow_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rd_en(rd_en),
  .rd_data(rd_data), .trig_sel(trig_sel), .clr_status(clr_status),
  .cts_n(cts_n), .tx_go(tx_go), .level(level), .empty(empty), .full(full),
  .irq(irq), .rts_n(rts_n), .overrun(overrun), .wr_fire(wr_fire),
  .rd_fire(rd_fire), .drop_evt(drop_evt)
);

// File: tb/rx_flow_fifo_test.sv
module rx_flow_fifo_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] trig_sel = 2'd0;
  logic       clr_status = 1'b0;
  logic       cts_n = 1'b0;
  logic       tx_req = 1'b0;
  logic       tx_go;
  logic [4:0] level;
  logic       empty, full, irq, rts_n, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state
  byte unsigned q[$];
  byte unsigned m_rd = 0;
  bit m_ovr = 1'b0;

  always #5 clk = ~clk;

  rx_flow_fifo uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .trig_sel(trig_sel),
    .clr_status(clr_status), .cts_n(cts_n), .tx_req(tx_req), .tx_go(tx_go),
    .level(level), .empty(empty), .full(full), .irq(irq), .rts_n(rts_n),
    .overrun(overrun)
  );

  function automatic int thr(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_rd  = 0;
      m_ovr = 1'b0;
    end else begin
      bit rdf, wrf;
      rdf = rd_en && (q.size() > 0);
      wrf = in_valid && ((q.size() < 16) || rdf);
      if (rdf) m_rd = q.pop_front();
      if (wrf) q.push_back(in_data);
      if (in_valid && !wrf) m_ovr = 1'b1;
      else if (clr_status)  m_ovr = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n;
    bit at;
    n  = q.size();
    at = (n >= thr(trig_sel));
    check(int'(level) == n, "R1 level", int'(level), n);
    check(empty == (n == 0), "R1 empty", empty, n == 0);
    check(full == (n == 16), "R1 full", full, n == 16);
    check(rd_data == m_rd, "R2 rd_data", rd_data, m_rd);
    check(irq == at, "R4 irq", irq, at);
    check(rts_n == at, "R5 rts_n", rts_n, at);
    check(tx_go == (tx_req && !cts_n), "R6 tx_go", tx_go, tx_req && !cts_n);
    check(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input bit v, input byte unsigned d, input bit r);
    in_valid = v;
    in_data  = d;
    rd_en    = r;
    step();
    in_valid = 1'b0;
    rd_en    = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(level == 0 && empty && !full, "R10 level/empty", level, 0);
    check(rd_data == 0, "R10 rd_data", rd_data, 0);
    check(!overrun && !irq, "R10 overrun/irq", {overrun, irq}, 0);
    rst_n = 1'b1;
    step();

    // R4, R5: threshold 1
    trig_sel = 2'd0;
    drive(1, 8'hA1, 0);
    check(irq && rts_n, "R4 trig1 irq", irq, 1);
    drive(0, 0, 1);
    check(rd_data == 8'hA1, "R2 first read", rd_data, 8'hA1);
    check(!rts_n, "R5 rts drop", rts_n, 0);

    // R3: empty read
    drive(0, 0, 1);
    check(rd_data == 8'hA1 && level == 0, "R3 empty read", rd_data, 8'hA1);

    // Fill to 16, sweeping thresholds along the way
    for (int i = 0; i < 16; i++) begin
      trig_sel = 2'(i % 4);
      drive(1, 8'(8'h10 + i), 0);
    end
    trig_sel = 2'd3;
    step();
    check(full && level == 16, "R1 full at 16", level, 16);

    // R7: dropped write
    drive(1, 8'hEE, 0);
    check(overrun && level == 16, "R7 drop", {overrun, level}, {1'b1, 5'd16});

    // R8: clear coincident with a drop keeps it set, then clear alone
    clr_status = 1'b1;
    drive(1, 8'hEF, 0);
    check(overrun, "R8 set wins", overrun, 1);
    drive(0, 0, 0);
    clr_status = 1'b0;
    check(!overrun, "R8 cleared", overrun, 0);

    // R9: write and read together while full
    drive(1, 8'h5A, 1);
    check(level == 16 && !overrun, "R9 full pass", level, 16);
    check(rd_data == 8'h10, "R9 oldest out", rd_data, 8'h10);

    // Drain with threshold 8, crossing it
    trig_sel = 2'd2;
    for (int i = 0; i < 18; i++) drive(0, 0, 1);
    check(rd_data == 8'h5A && empty, "R2 order tail", rd_data, 8'h5A);

    // R6: clear-to-send gating
    tx_req = 1'b1; cts_n = 1'b1; step();
    check(!tx_go, "R6 blocked", tx_go, 0);
    cts_n = 1'b0; step();
    check(tx_go, "R6 passes", tx_go, 1);
    tx_req = 1'b0;

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      in_valid   = ($urandom % 3) != 0;
      in_data    = 8'($urandom);
      rd_en      = ($urandom % 3) == 0;
      clr_status = ($urandom % 16) == 0;
      trig_sel   = 2'($urandom);
      cts_n      = $urandom % 2;
      tx_req     = $urandom % 2;
      step();
    end
    in_valid = 0; rd_en = 0; clr_status = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule